// File: doc/BRIEF.md
# Audio DMA Stream Status Logic

This block holds the 8-bit status register of one audio DMA stream engine and the event logic that feeds it. The stream engine reports raw events on plain pins: a failed descriptor fetch, a link slot or sample strobe, the FIFO's full and empty state, whether buffers remain to send, and the end of a buffer. The block qualifies these events against the stream's RUN state and captures them in three sticky flags. Software reads the register and clears a flag by writing a one to its bit. A read-only readiness flag reflects the engine's current state.

The parameter `IS_INPUT` selects the stream direction. An input stream receives samples from the link. The link cannot be stalled, so `link_stb` is a valid with no ready: a sample that arrives while the FIFO is full is an overrun and is dropped, and `fifo_adv` (the write-pointer advance) stays low. An output stream gets a slot request on `link_stb`. `fifo_adv` then acts as the accept and read-pointer advance. When the FIFO is empty and buffers remain, the slot is an underrun and nothing is sent. The block owns the RUN bit. A descriptor fault forces RUN off, and software cannot set RUN again until it has cleared the descriptor error flag. `irq` is a level request built from the sticky flags and their enable pins.

Top module: `dma_strm_status`

## Requirements
- R1: After reset `sw_rdata` is 00h and `run` and `irq` are 0.
- R2: Bits 7, 6, 1 and 0 of `sw_rdata` always read 0. A write affects only bits 4, 3 and 2, so writes to bits 7:5 and 1:0 change nothing.
- R3: Bit 5 (ready) takes, one cycle later, the value of `desc_loaded` for an input stream or `fifo_enough` for an output stream.
- R4: `desc_fault` sets bit 4 (descriptor error) and clears `run` on the next cycle, whatever `sw_run_set` does in that cycle.
- R5: `sw_run_set` sets `run` on the next cycle only while bit 4 is 0. `sw_run_clr` clears `run` and takes priority over `sw_run_set`.
- R6: Input stream: `fifo_adv` = `run` & `link_stb` & !`fifo_full`. If `run` & `link_stb` & `fifo_full` (overrun), bit 3 (FIFO error) sets on the next cycle and `fifo_adv` stays 0.
- R7: Output stream: `fifo_adv` = `run` & `link_stb` & !`fifo_empty`. If `run` & `link_stb` & `fifo_empty` & `bufs_left` (underrun), bit 3 sets on the next cycle. With `bufs_left` low, an empty FIFO sets nothing.
- R8: Bit 2 (completion) sets on the next cycle when `buf_done` and `buf_ioc` are both high. `buf_done` alone has no effect.
- R9: A write with a 1 in bit 4, 3 or 2 clears that flag on the next cycle. A 0 in that bit leaves the flag unchanged.
- R10: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up 1.
- R11: `irq` = (bit2 & `en_comp`) | (bit3 & `en_ferr`) | (bit4 & `en_derr`), with no added delay from the flags or the enables.
- R12: Bit 3 sets on a FIFO error even when `en_ferr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Software register write strobe |
| sw_wdata | input | 8 | Write data; a 1 clears that flag |
| sw_rdata | output | 8 | Register read value |
| sw_run_set | input | 1 | Request to set RUN |
| sw_run_clr | input | 1 | Request to clear RUN |
| run | output | 1 | Stream RUN bit |
| desc_loaded | input | 1 | Input stream: a valid descriptor is loaded |
| fifo_enough | input | 1 | Output stream: the FIFO holds enough data for the link |
| desc_fault | input | 1 | Descriptor fetch failed |
| link_stb | input | 1 | Link sample (input) or slot request (output) |
| fifo_full | input | 1 | FIFO full |
| fifo_empty | input | 1 | FIFO empty |
| bufs_left | input | 1 | Buffers remain to be sent |
| fifo_adv | output | 1 | FIFO pointer advance / sample accepted |
| buf_done | input | 1 | Last sample of a buffer processed |
| buf_ioc | input | 1 | The finished buffer's descriptor asks for a completion interrupt |
| en_comp | input | 1 | Completion interrupt enable |
| en_ferr | input | 1 | FIFO error interrupt enable |
| en_derr | input | 1 | Descriptor error interrupt enable |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can fall in the same cycle: a hardware event that sets a flag and a software write-1 that clears the same flag. The bench makes them coincide for the completion, FIFO error and descriptor error flags, in both stream directions. The flag must read 1 afterwards. A second collision is a descriptor fault in the same cycle as a RUN-set request, after which RUN must read 0. The bench judges every cycle against its behavioural model, and it also runs explicit tagged checks on these cycles.

// File: rtl/dma_strm_pkg.sv
package dma_strm_pkg;
  localparam int STS_W   = 8;
  localparam int FLAG_N  = 3;
  localparam int BIT_CMP = 2;
  localparam int BIT_FER = 3;
  localparam int BIT_DER = 4;
  localparam int BIT_RDY = 5;

  typedef struct packed {
    logic derr;
    logic ferr;
    logic cmp;
  } flags_t;
endpackage

// File: rtl/dma_strm_sticky.sv
module dma_strm_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)           q_o[i] <= 1'b0;
      else if (set_i[i])    q_o[i] <= 1'b1;
      else if (clr_i[i])    q_o[i] <= 1'b0;
    end

    // R10: a set event wins over a same-cycle clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_o[i]);
    // R9: a lone clear drops the flag
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    // R9: with no set and no clear the flag holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));
  end
endmodule

// File: rtl/dma_strm_evt_qual.sv
module dma_strm_evt_qual #(
  parameter bit IS_INPUT = 1'b1
) (
  input  logic run_i,
  input  logic link_stb,
  input  logic fifo_full,
  input  logic fifo_empty,
  input  logic bufs_left,
  input  logic desc_loaded,
  input  logic fifo_enough,
  output logic fifo_adv,
  output logic ferr_evt,
  output logic rdy_src
);
  if (IS_INPUT) begin : g_in
    logic dir_unused;
    assign dir_unused = ^{fifo_empty, bufs_left, fifo_enough};
    always_comb begin
      fifo_adv = run_i & link_stb & ~fifo_full;
      ferr_evt = run_i & link_stb & fifo_full;
      rdy_src  = desc_loaded;
    end
  end else begin : g_out
    logic dir_unused;
    assign dir_unused = ^{fifo_full, desc_loaded};
    always_comb begin
      fifo_adv = run_i & link_stb & ~fifo_empty;
      ferr_evt = run_i & link_stb & fifo_empty & bufs_left;
      rdy_src  = fifo_enough;
    end
  end
endmodule

// File: rtl/dma_strm_run_ctl.sv
module dma_strm_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_set,
  input  logic run_clr,
  input  logic desc_fault,
  input  logic derr_q,
  output logic run_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                      run_q <= 1'b0;
    else if (desc_fault)             run_q <= 1'b0;
    else if (run_clr)                run_q <= 1'b0;
    else if (run_set && !derr_q)     run_q <= 1'b1;
  end

  // R4: a fault always stops the stream
  p_fault_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_fault |=> !run_q);
  // R5: no restart while the descriptor error flag is up
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (derr_q && !run_q) |=> !run_q);
  // R5: clear request wins
  p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_clr |=> !run_q);
endmodule

// File: rtl/dma_strm_status.sv
module dma_strm_status #(
  parameter bit IS_INPUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_wr,
  input  logic [7:0] sw_wdata,
  output logic [7:0] sw_rdata,
  input  logic       sw_run_set,
  input  logic       sw_run_clr,
  output logic       run,
  input  logic       desc_loaded,
  input  logic       fifo_enough,
  input  logic       desc_fault,
  input  logic       link_stb,
  input  logic       fifo_full,
  input  logic       fifo_empty,
  input  logic       bufs_left,
  output logic       fifo_adv,
  input  logic       buf_done,
  input  logic       buf_ioc,
  input  logic       en_comp,
  input  logic       en_ferr,
  input  logic       en_derr,
  output logic       irq
);
  import dma_strm_pkg::*;

  flags_t flag_set, flag_clr, flag_q, flag_en;
  logic   ferr_evt, rdy_src, rdy_q;
  logic   wdata_unused;

  assign wdata_unused = ^{sw_wdata[7:5], sw_wdata[1:0]};

  dma_strm_evt_qual #(.IS_INPUT(IS_INPUT)) u_qual (
    .run_i(run), .link_stb(link_stb), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .bufs_left(bufs_left),
    .desc_loaded(desc_loaded), .fifo_enough(fifo_enough),
    .fifo_adv(fifo_adv), .ferr_evt(ferr_evt), .rdy_src(rdy_src)
  );

  always_comb begin
    flag_set.derr = desc_fault;
    flag_set.ferr = ferr_evt;
    flag_set.cmp  = buf_done & buf_ioc;
    flag_clr.derr = sw_wr & sw_wdata[BIT_DER];
    flag_clr.ferr = sw_wr & sw_wdata[BIT_FER];
    flag_clr.cmp  = sw_wr & sw_wdata[BIT_CMP];
    flag_en.derr  = en_derr;
    flag_en.ferr  = en_ferr;
    flag_en.cmp   = en_comp;
  end

  dma_strm_sticky #(.N(FLAG_N)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr), .q_o(flag_q)
  );

  dma_strm_run_ctl u_run (
    .clk(clk), .rst_n(rst_n), .run_set(sw_run_set), .run_clr(sw_run_clr),
    .desc_fault(desc_fault), .derr_q(flag_q.derr), .run_q(run)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_src;
  end

  always_comb begin
    sw_rdata          = '0;
    sw_rdata[BIT_RDY] = rdy_q;
    sw_rdata[BIT_DER] = flag_q.derr;
    sw_rdata[BIT_FER] = flag_q.ferr;
    sw_rdata[BIT_CMP] = flag_q.cmp;
  end

  assign irq = |(flag_q & flag_en);

  // R2: reserved bits never read as one
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata[7:6] == 2'b00) && (sw_rdata[1:0] == 2'b00));
  // R11: no request without a raised flag
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata[4:2] == 3'b000) |-> !irq);
  // R12: FIFO error captured regardless of enable
  p_ferr_capture_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (run && link_stb && (IS_INPUT ? fifo_full : (fifo_empty && bufs_left)))
      |=> sw_rdata[3]);
  // R6/R7: a stalled FIFO never advances
  p_no_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_INPUT ? fifo_full : fifo_empty) |-> !fifo_adv);
endmodule

// File: tb/dma_strm_status_bench.sv
module dma_strm_status_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       sw_wr, sw_run_set, sw_run_clr;
  logic [7:0] sw_wdata;
  logic       desc_loaded, fifo_enough, desc_fault, link_stb;
  logic       fifo_full, fifo_empty, bufs_left, buf_done, buf_ioc;
  logic       en_comp, en_ferr, en_derr;
  logic [7:0] rd   [2];
  logic       runo [2];
  logic       adv  [2];
  logic       irqo [2];

  int compared = 0;
  int mismatched = 0;

  // model state, index 0 = input stream, 1 = output stream
  bit m_run [2], m_de [2], m_fe [2], m_bc [2], m_rdy [2];

  dma_strm_status #(.IS_INPUT(1'b1)) u_dma_strm_status (
    .clk, .rst_n, .sw_wr, .sw_wdata, .sw_rdata(rd[0]), .sw_run_set, .sw_run_clr,
    .run(runo[0]), .desc_loaded, .fifo_enough, .desc_fault, .link_stb,
    .fifo_full, .fifo_empty, .bufs_left, .fifo_adv(adv[0]), .buf_done,
    .buf_ioc, .en_comp, .en_ferr, .en_derr, .irq(irqo[0]));

  dma_strm_status #(.IS_INPUT(1'b0)) u_dma_strm_status_o (
    .clk, .rst_n, .sw_wr, .sw_wdata, .sw_rdata(rd[1]), .sw_run_set, .sw_run_clr,
    .run(runo[1]), .desc_loaded, .fifo_enough, .desc_fault, .link_stb,
    .fifo_full, .fifo_empty, .bufs_left, .fifo_adv(adv[1]), .buf_done,
    .buf_ioc, .en_comp, .en_ferr, .en_derr, .irq(irqo[1]));

  task automatic chk(string tag, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  task automatic compare_all();
    for (int d = 0; d < 2; d++) begin
      automatic bit ev_adv = m_run[d] && link_stb &&
                             (d == 0 ? !fifo_full : !fifo_empty);
      automatic bit ev_irq = (m_bc[d] && en_comp) || (m_fe[d] && en_ferr) ||
                             (m_de[d] && en_derr);
      chk("R2 reserved bits", {rd[d][7:6], rd[d][1:0]}, 0);
      chk("R3 ready", rd[d][5], m_rdy[d]);
      chk("R4 desc error", rd[d][4], m_de[d]);
      chk(d == 0 ? "R6 fifo error" : "R7 fifo error", rd[d][3], m_fe[d]);
      chk("R8 completion", rd[d][2], m_bc[d]);
      chk("R5 run", runo[d], m_run[d]);
      chk(d == 0 ? "R6 advance" : "R7 advance", adv[d], ev_adv);
      chk("R11 irq", irqo[d], ev_irq);
    end
  endtask

  // one clock: model takes the inputs present at the edge
  task automatic step();
    bit n_run [2], n_de [2], n_fe [2], n_bc [2], n_rdy [2];
    for (int d = 0; d < 2; d++) begin
      automatic bit fe_ev = (d == 0) ? (m_run[d] && link_stb && fifo_full)
                                     : (m_run[d] && link_stb && fifo_empty && bufs_left);
      automatic bit w4 = sw_wr && sw_wdata[4];
      automatic bit w3 = sw_wr && sw_wdata[3];
      automatic bit w2 = sw_wr && sw_wdata[2];
      if (desc_fault)                  n_run[d] = 0;
      else if (sw_run_clr)             n_run[d] = 0;
      else if (sw_run_set && !m_de[d]) n_run[d] = 1;
      else                             n_run[d] = m_run[d];
      n_de[d]  = desc_fault || (m_de[d] && !w4);
      n_fe[d]  = fe_ev || (m_fe[d] && !w3);
      n_bc[d]  = (buf_done && buf_ioc) || (m_bc[d] && !w2);
      n_rdy[d] = (d == 0) ? desc_loaded : fifo_enough;
    end
    @(posedge clk);
    @(negedge clk);
    m_run = n_run; m_de = n_de; m_fe = n_fe; m_bc = n_bc; m_rdy = n_rdy;
    compare_all();
  endtask

  task automatic idle_inputs();
    sw_wr = 0; sw_wdata = 0; sw_run_set = 0; sw_run_clr = 0;
    desc_fault = 0; link_stb = 0; buf_done = 0; buf_ioc = 0;
  endtask

  task automatic wr(logic [7:0] v);
    sw_wr = 1; sw_wdata = v; step(); sw_wr = 0; sw_wdata = 0;
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle_inputs();
    desc_loaded = 1; fifo_enough = 1; fifo_full = 0; fifo_empty = 0; bufs_left = 0;
    en_comp = 0; en_ferr = 0; en_derr = 0;
    for (int d = 0; d < 2; d++) begin
      m_run[d] = 0; m_de[d] = 0; m_fe[d] = 0; m_bc[d] = 0; m_rdy[d] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset rdata", rd[0], 0); chk("R1 reset rdata out", rd[1], 0);
    chk("R1 reset run", runo[0], 0); chk("R1 reset irq", irqo[0], 0);
    rst_n = 1;
    desc_loaded = 0; fifo_enough = 0;

    // R3 ready follows per-direction source
    desc_loaded = 1; step(); chk("R3 input ready", rd[0][5], 1); chk("R3 output not ready", rd[1][5], 0);
    desc_loaded = 0; fifo_enough = 1; step(); chk("R3 input drop", rd[0][5], 0); chk("R3 output ready", rd[1][5], 1);

    // R2 reserved and read-only write ignored
    wr(8'hE3); chk("R2 write ignored", rd[0], 8'h00); chk("R2 write ignored out", rd[1], 8'h20);

    // R5 run set
    sw_run_set = 1; step(); sw_run_set = 0; chk("R5 run set", runo[0], 1);
    sw_run_set = 1; sw_run_clr = 1; step(); sw_run_set = 0; sw_run_clr = 0; chk("R5 clr wins", runo[0], 0);
    sw_run_set = 1; step(); sw_run_set = 0;

    // R6/R7 streaming with full/empty patterns
    for (int k = 0; k < 12; k++) begin
      link_stb = (k % 3 != 2); fifo_full = (k % 4 == 1); fifo_empty = (k % 5 == 0);
      bufs_left = (k % 2 == 0);
      step();
    end
    link_stb = 1; fifo_full = 1; fifo_empty = 1; bufs_left = 0;
    #1 chk("R6 no push on overrun", adv[0], 0); chk("R7 no send when empty", adv[1], 0);
    step(); link_stb = 0;
    chk("R12 ferr set with enable low", rd[0][3], 1);
    wr(8'h08); chk("R9 clear ferr", rd[0][3], 0);
    link_stb = 1; fifo_empty = 1; bufs_left = 1; fifo_full = 0; step(); link_stb = 0;
    chk("R7 underrun", rd[1][3], 1);
    fifo_empty = 0;

    // R8 completion
    buf_done = 1; buf_ioc = 0; step(); chk("R8 no ioc", rd[0][2], 0);
    buf_ioc = 1; step(); buf_done = 0; buf_ioc = 0; chk("R8 set", rd[0][2], 1);
    wr(8'h00); chk("R9 write zero keeps", rd[0][2], 1);

    // R11 enables
    en_comp = 1; #1 chk("R11 comp irq", irqo[0], 1);
    en_ferr = 1; en_derr = 1; step();
    en_comp = 0; step();

    // R10 set vs clear same cycle
    buf_done = 1; buf_ioc = 1; sw_wr = 1; sw_wdata = 8'h1C;
    link_stb = 1; fifo_full = 1; fifo_empty = 1; bufs_left = 1;
    step(); idle_inputs(); fifo_full = 0; fifo_empty = 0;
    chk("R10 completion set wins", rd[0][2], 1); chk("R10 ferr set wins", rd[1][3], 1);
    wr(8'h1C); chk("R9 all clear", rd[0][4:2], 0);

    // R4 fault while run, with run set in the same cycle
    desc_fault = 1; sw_run_set = 1; sw_wr = 1; sw_wdata = 8'h10;
    step(); idle_inputs();
    chk("R4 run cleared", runo[0], 0); chk("R10 derr set wins", rd[0][4], 1);
    sw_run_set = 1; step(); sw_run_set = 0; chk("R5 restart blocked", runo[0], 0);
    wr(8'h10); chk("R9 derr cleared", rd[0][4], 0);
    sw_run_set = 1; step(); sw_run_set = 0; chk("R5 restart ok", runo[1], 1);
    en_derr = 1; desc_fault = 1; step(); desc_fault = 0; chk("R11 derr irq", irqo[0], 1);
    wr(8'h10); chk("R11 irq drops", irqo[0], 0);
    repeat (4) step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule